// File: doc/BRIEF.md
# Tile-Fetch Driven Character Bank Switcher

This block steers the pattern-memory mapping of a tile-based video system. The 8 KB pattern space is split into a lower and an upper 4 KB half. Each half has two bank registers preloaded by the CPU and a two-state selector. The selector flips when the video processor is seen fetching one of two marker tile rows in that half. A game can therefore swap the graphics of one half partway through a frame with no CPU involvement.

CPU writes are decoded on three upper address bits. These writes load the four character bank registers, the bank number of the first 8 KB program slot, and the nametable mirroring control. The other three program slots are tied to the last three 8 KB banks of the program memory.

The block watches the video fetch address, qualified by a fetch-valid strobe. It drives the current 4 KB bank number for each half, the four program slot bank numbers, and the mirroring flag. It does not contain the video processor or any memory.

Top module: `fetch_bank_switch`

## Requirements
- R1: A valid fetch whose address bits 12:4 equal 0x0FD (that is, address & 0x1FF0 == 0x0FD0; bit 13 is ignored) puts the lower selector in its "A" state. Bits 12:4 equal to 0x0FE put it in its "B" state. The new state shows on the outputs from the cycle after the strobe.
- R2: A valid fetch with address & 0x1FF0 equal to 0x1FD0 puts the upper selector in state A. A valid fetch with 0x1FE0 puts it in state B.
- R3: A fetch at any other address, or any address presented while `vid_fetch_valid` is low, leaves both selectors unchanged. During the strobe cycle itself, the outputs still show the old bank.
- R4: `chr_lo_bank` equals character register 0 when the lower selector is in state A and register 1 when it is in state B. `chr_hi_bank` equals register 2 in state A and register 3 in state B.
- R5: A write with `cpu_addr[14:12]` equal to 3, 4, 5 or 6 loads `cpu_wdata[CHR_W-1:0]` into character register 0, 1, 2 or 3. A bank output changes in the next cycle only if its selector currently picks the written register.
- R6: A write with `cpu_addr[14:12]` equal to 2 loads `cpu_wdata[PRG_W-1:0]` as the slot 0 program bank. `prg_banks` carries slot k in bits [k*PRG_W +: PRG_W]. Slots 1, 2 and 3 are always PRG_BANKS-3, PRG_BANKS-2 and PRG_BANKS-1.
- R7: A write with `cpu_addr[14:12]` equal to 7 sets `mirror_horiz` to `cpu_wdata[0]`, where 1 means horizontal and 0 means vertical.
- R8: Writes with `cpu_addr[14:12]` equal to 0 or 1, and any cycle with `cpu_we` low, change no output.
- R9: While `rst_n` is low at a clock edge, both selectors go to state B, all four character registers and the slot 0 bank go to zero, and `mirror_horiz` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | CPU_AW (15) | CPU write address; bits 14:12 choose the target |
| cpu_wdata | input | DW (8) | CPU write data |
| vid_fetch_valid | input | 1 | Video pattern fetch strobe |
| vid_addr | input | VA_W (14) | Video pattern fetch address |
| chr_lo_bank | output | CHR_W (5) | 4 KB bank for the lower pattern half |
| chr_hi_bank | output | CHR_W (5) | 4 KB bank for the upper pattern half |
| prg_banks | output | 4*PRG_W (16) | Four 8 KB program slot banks, slot 0 in the low bits |
| mirror_horiz | output | 1 | 1 selects horizontal mirroring, 0 vertical |

## Verification
A selector stuck in the wrong state, or flipped by a non-marker address, shows as the wrong register on a bank output in the cycle after the fetch. It stays wrong until the next marker fetch, so each fetch check is followed by writes that would expose a wrong selection. A corrupted bank register appears only while its selector picks it. For that reason every register is written both while selected and while hidden, and is then brought out by a later marker fetch. Decode errors appear one cycle after the write, on the slot 0 bank, on the mirroring flag, or on a bank output that should not have moved.

// File: rtl/fbl_pkg.sv
// Shared types for the fetch-driven bank switcher.
// Assumes: write target is a 3-bit field taken from the CPU address.
package fbl_pkg;

    // Two-state selector of one pattern half: A picks the first register, B the second
    typedef enum logic {
        SEL_B = 1'b0,
        SEL_A = 1'b1
    } half_sel_t;

    // Write targets decoded from the CPU address field
    localparam logic [2:0] TGT_PRG0  = 3'd2;
    localparam logic [2:0] TGT_CHR0  = 3'd3;
    localparam logic [2:0] TGT_CHR3  = 3'd6;
    localparam logic [2:0] TGT_MIRR  = 3'd7;

endpackage

// File: rtl/fbl_cpu_regs.sv
// CPU-side register file: four character bank registers, the slot 0 program
// bank and the mirroring flag.
// Assumes: CHR_W and PRG_W do not exceed DW; the target field is 3 bits wide.
module fbl_cpu_regs
    import fbl_pkg::*;
#(
    parameter int DW    = 8,
    parameter int CHR_W = 5,
    parameter int PRG_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [2:0]             tgt,
    input  logic [DW-1:0]          wdata,
    output logic [3:0][CHR_W-1:0]  chr_regs,
    output logic [PRG_W-1:0]       prg0,
    output logic                   mirror_h
);

    logic unused_data;
    assign unused_data = ^wdata;

    // Character registers: each one loads from its own target code
    for (genvar i = 0; i < 4; i++) begin : g_chr
        localparam logic [2:0] MY_TGT = TGT_CHR0 + 3'(i);
        always_ff @(posedge clk) begin
            if (!rst_n)
                chr_regs[i] <= '0;
            else if (we && tgt == MY_TGT)
                chr_regs[i] <= wdata[CHR_W-1:0];
        end
    end

    // Slot 0 program bank and mirroring flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prg0     <= '0;
            mirror_h <= 1'b0;
        end else if (we) begin
            if (tgt == TGT_PRG0) prg0     <= wdata[PRG_W-1:0];
            if (tgt == TGT_MIRR) mirror_h <= wdata[0];
        end
    end

    // R6: a program write shows on slot 0 in the next cycle
    a_r6_prg_load: assert property (@(posedge clk) disable iff (!rst_n)
        (we && tgt == TGT_PRG0) |=> (prg0 == $past(wdata[PRG_W-1:0])));

    // R7: a mirroring write shows its bit 0 in the next cycle
    a_r7_mirror_load: assert property (@(posedge clk) disable iff (!rst_n)
        (we && tgt == TGT_MIRR) |=> (mirror_h == $past(wdata[0])));

    // R8: writes to targets 0 and 1 leave everything unchanged
    a_r8_ignored_tgt: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || tgt < TGT_PRG0) |=> ($stable(chr_regs) && $stable(prg0) && $stable(mirror_h)));

endmodule

// File: rtl/fbl_half_ctrl.sv
// One pattern half: snoops fetch addresses for its two marker rows, keeps a
// two-state selector and picks one of its two bank registers.
// Assumes: the marker compare uses address bits 12:4; bit 12 names the half.
module fbl_half_ctrl
    import fbl_pkg::*;
#(
    parameter int      VA_W  = 14,
    parameter int      CHR_W = 5,
    parameter bit      HALF  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic [VA_W-1:0]  fetch_addr,
    input  logic [CHR_W-1:0] bank_a,
    input  logic [CHR_W-1:0] bank_b,
    output half_sel_t        sel,
    output logic [CHR_W-1:0] bank_out
);

    localparam logic [8:0] KEY_A = {HALF, 8'hFD};
    localparam logic [8:0] KEY_B = {HALF, 8'hFE};

    logic [8:0] key;
    logic       hit_a, hit_b;

    // Marker row detection on the masked fetch address
    always_comb begin
        key   = fetch_addr[12:4];
        hit_a = fetch_valid && (key == KEY_A);
        hit_b = fetch_valid && (key == KEY_B);
    end

    // Selector state: flips only on a marker fetch
    always_ff @(posedge clk) begin
        if (!rst_n)     sel <= SEL_B;
        else if (hit_a) sel <= SEL_A;
        else if (hit_b) sel <= SEL_B;
    end

    // Bank choice for this half
    always_comb bank_out = (sel == SEL_A) ? bank_a : bank_b;

    // R1 / R2: a marker A fetch leaves the selector in state A
    a_r1_mark_a: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_addr[12:4] == KEY_A) |=> (sel == SEL_A));

    // R1 / R2: a marker B fetch leaves the selector in state B
    a_r2_mark_b: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_addr[12:4] == KEY_B) |=> (sel == SEL_B));

    // R3: no marker fetch, no change
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_a || hit_b) |=> $stable(sel));

endmodule

// File: rtl/fbl_prg_map.sv
// Program slot map: slot 0 follows the CPU register, slots 1..3 are tied to
// the last three 8 KB banks.
// Assumes: PRG_BANKS is at least 4 and fits in PRG_W bits.
module fbl_prg_map #(
    parameter int PRG_W     = 4,
    parameter int PRG_BANKS = 16
) (
    input  logic [PRG_W-1:0]   slot0,
    output logic [4*PRG_W-1:0] slots
);

    // Slot 0 passes through
    assign slots[PRG_W-1:0] = slot0;

    // Fixed slots count up to the last bank
    for (genvar k = 1; k < 4; k++) begin : g_fixed
        assign slots[k*PRG_W +: PRG_W] = PRG_W'(PRG_BANKS - 4 + k);
    end

endmodule

// File: rtl/fetch_bank_switch.sv
// Top: decodes CPU writes, runs one selector per pattern half and drives the
// current character and program bank numbers plus mirroring.
// Assumes: synchronous active-low reset; outputs follow registers directly.
module fetch_bank_switch
    import fbl_pkg::*;
#(
    parameter int CPU_AW    = 15,
    parameter int DW        = 8,
    parameter int VA_W      = 14,
    parameter int CHR_W     = 5,
    parameter int PRG_BANKS = 16,
    parameter int PRG_W     = $clog2(PRG_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_we,
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic [DW-1:0]        cpu_wdata,
    input  logic                 vid_fetch_valid,
    input  logic [VA_W-1:0]      vid_addr,
    output logic [CHR_W-1:0]     chr_lo_bank,
    output logic [CHR_W-1:0]     chr_hi_bank,
    output logic [4*PRG_W-1:0]   prg_banks,
    output logic                 mirror_horiz
);

    localparam int TGT_LSB = CPU_AW - 3;

    logic [2:0]             tgt;
    logic [3:0][CHR_W-1:0]  chr_regs;
    logic [PRG_W-1:0]       prg0;
    half_sel_t              sel [2];
    logic [CHR_W-1:0]       half_bank [2];
    logic                   unused_addr;

    assign tgt         = cpu_addr[CPU_AW-1:TGT_LSB];
    assign unused_addr = ^{cpu_addr, vid_addr};

    fbl_cpu_regs #(.DW(DW), .CHR_W(CHR_W), .PRG_W(PRG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cpu_we),
        .tgt      (tgt),
        .wdata    (cpu_wdata),
        .chr_regs (chr_regs),
        .prg0     (prg0),
        .mirror_h (mirror_horiz)
    );

    // One selector and mux per 4 KB pattern half
    for (genvar h = 0; h < 2; h++) begin : g_half
        fbl_half_ctrl #(.VA_W(VA_W), .CHR_W(CHR_W), .HALF(h[0])) u_half (
            .clk         (clk),
            .rst_n       (rst_n),
            .fetch_valid (vid_fetch_valid),
            .fetch_addr  (vid_addr),
            .bank_a      (chr_regs[2*h]),
            .bank_b      (chr_regs[2*h+1]),
            .sel         (sel[h]),
            .bank_out    (half_bank[h])
        );
    end

    assign chr_lo_bank = half_bank[0];
    assign chr_hi_bank = half_bank[1];

    fbl_prg_map #(.PRG_W(PRG_W), .PRG_BANKS(PRG_BANKS)) u_prg (
        .slot0 (prg0),
        .slots (prg_banks)
    );

    // R5: a write to the selected lower register shows on the lower output next cycle
    a_r5_lo_live_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && tgt == TGT_CHR0 && sel[0] == SEL_A && !vid_fetch_valid)
        |=> (chr_lo_bank == $past(cpu_wdata[CHR_W-1:0])));

    // R5: a write to the selected upper register shows on the upper output next cycle
    a_r5_hi_live_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && tgt == TGT_CHR3 && sel[1] == SEL_B && !vid_fetch_valid)
        |=> (chr_hi_bank == $past(cpu_wdata[CHR_W-1:0])));

    // R4: with no write and no fetch, both bank outputs hold
    a_r4_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_we && !vid_fetch_valid) |=> ($stable(chr_lo_bank) && $stable(chr_hi_bank)));

endmodule

// File: tb/sim_fetch_bank_switch.sv
module sim_fetch_bank_switch;

    localparam int NV = 18;
    // op: 0 = CPU write, 1 = valid fetch
    localparam int V_OP   [NV] = '{0,0,0,0,1,1,1,1,1,1,0,0,0,0,0,0,0,1};
    localparam int V_ADDR [NV] = '{'h3000,'h4000,'h5000,'h6000,'h0FD3,'h1FE0,'h1FD7,'h2FE5,'h0FC0,
                                   'h0FF0,'h2000,'h7000,'h7000,'h0000,'h1FFF,'h5ABC,'h3000,'h0FD0};
    localparam int V_DATA [NV] = '{'h05,'h0A,'h13,'h1E,0,0,0,0,0,0,'h37,'h01,'hFE,'h1F,'h1F,'hE4,'h09,0};
    localparam int V_LO   [NV] = '{0,10,10,10,5,5,5,10,10,10,10,10,10,10,10,10,10,9};
    localparam int V_HI   [NV] = '{0,0,0,30,30,30,19,19,19,19,19,19,19,19,19,4,4,4};
    localparam int V_PRG  [NV] = '{0,0,0,0,0,0,0,0,0,0,7,7,7,7,7,7,7,7};
    localparam int V_MIR  [NV] = '{0,0,0,0,0,0,0,0,0,0,0,1,0,0,0,0,0,0};
    localparam string V_REQ [NV] = '{"R5","R5","R5","R5","R1","R2","R2","R1","R3",
                                     "R3","R6","R7","R7","R8","R8","R5","R5","R4"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_we = 1'b0;
    logic [14:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        vid_fetch_valid = 1'b0;
    logic [13:0] vid_addr = '0;
    logic [4:0]  chr_lo_bank, chr_hi_bank;
    logic [15:0] prg_banks;
    logic        mirror_horiz;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fetch_bank_switch u0 (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .vid_fetch_valid(vid_fetch_valid), .vid_addr(vid_addr),
        .chr_lo_bank(chr_lo_bank), .chr_hi_bank(chr_hi_bank),
        .prg_banks(prg_banks), .mirror_horiz(mirror_horiz)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic check_state(input string req, input int lo, input int hi, input int prg, input int mir);
        chk(req, "chr_lo_bank", int'(chr_lo_bank), lo);
        chk(req, "chr_hi_bank", int'(chr_hi_bank), hi);
        chk(req, "prg slot0", int'(prg_banks[3:0]), prg);
        chk(req, "mirror_horiz", int'(mirror_horiz), mir);
        chk("R6", "fixed slots", int'(prg_banks[15:4]), 'hFED);
    endtask

    // Drive one cycle of stimulus at the falling edge, release after the rising edge
    task automatic do_op(input int op, input int addr, input int data, input bit strobe);
        @(negedge clk);
        if (op == 0) begin
            cpu_we = strobe; cpu_addr = 15'(addr); cpu_wdata = 8'(data);
        end else begin
            vid_fetch_valid = strobe; vid_addr = 14'(addr);
        end
        @(posedge clk);
        #1;
        cpu_we = 1'b0;
        vid_fetch_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R9: reset state
        check_state("R9", 0, 0, 0, 0);

        for (int i = 0; i < NV; i++) begin
            do_op(V_OP[i], V_ADDR[i], V_DATA[i], 1'b1);
            check_state(V_REQ[i], V_LO[i], V_HI[i], V_PRG[i], V_MIR[i]);
        end

        // R3: marker address without the strobe does nothing (lower half is in state A)
        do_op(1, 'h0FE0, 0, 1'b0);
        chk("R3", "no strobe", int'(chr_lo_bank), 9);

        // R3: during the strobe cycle the old bank is still shown, new one after the edge
        @(negedge clk);
        vid_fetch_valid = 1'b1; vid_addr = 14'h0FE2;
        #1;
        chk("R3", "strobe cycle old bank", int'(chr_lo_bank), 9);
        @(posedge clk);
        #1;
        vid_fetch_valid = 1'b0;
        chk("R1", "after strobe new bank", int'(chr_lo_bank), 10);

        // R8: write strobe low to a character target has no effect (register 1 is live)
        do_op(0, 'h4000, 'h1B, 1'b0);
        chk("R8", "we low", int'(chr_lo_bank), 10);

        // R5: hidden upper register 3 written, then exposed by a marker fetch
        do_op(0, 'h6000, 'h11, 1'b1);
        chk("R5", "hidden write", int'(chr_hi_bank), 4);
        do_op(1, 'h1FE9, 0, 1'b1);
        chk("R2", "expose reg3", int'(chr_hi_bank), 17);

        // R9: reset mid-run returns everything to the reset state
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        check_state("R9", 0, 0, 0, 0);
        // R9: after reset the lower selector is in state B: a write to register 0 stays hidden
        do_op(0, 'h3000, 'h07, 1'b1);
        chk("R9", "selector B after reset", int'(chr_lo_bank), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule